// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the digital feedback divider of a frequency synthesizer. A dual-modulus prescaler divides the input clock by P or P+1. A swallow counter and a main counter both count prescaler output cycles, and together they steer the prescaler so that one output pulse appears every N = B·P + A input clocks. The base modulus P is picked from four values by a 2-bit mode input.

At the start of each output period the prescaler runs at P+1. Once the swallow counter has seen A prescaler cycles, the prescaler drops to P for the remaining B−A cycles. The settings are sampled only at a period boundary. A setting whose main value is below three, or below the swallow value, is flagged as an error. While such a setting is present the divider produces no pulses, and it starts again as soon as a legal setting is applied.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With a legal setting, divPulse rises once every B·P + A input clocks. modeSel selects P: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 64.
- R2: divPulse is high for exactly one input clock per period, and it is low on the clock that follows.
- R3: The first A prescaler cycles of a period divide by P+1 and the rest divide by P. With swallowVal = 0 the period is B·P, and with swallowVal = B it is B·(P+1).
- R4: cfgError is high, combinationally from the inputs, exactly when mainVal < 3 or mainVal < swallowVal. It is low for every other setting, including mainVal = 3.
- R5: If an illegal setting is present at a period boundary, the period that is ending still gives its pulse, and after that divPulse stays low. When a legal setting is applied while the divider is idle, it is loaded on the next clock edge and the first pulse comes N+1 clock samples later.
- R6: swallowVal, mainVal and modeSel are captured only at a period boundary. A change made during a period does not alter that period's length.
- R7: While the synchronous active-high reset is held, divPulse is low. After reset is released with a legal setting, the first pulse is seen N+1 clock samples later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 2 | Prescaler base modulus select |
| swallowVal | input | 6 | Swallow count A, 0 to 63 |
| mainVal | input | 13 | Main count B, 3 to 8191 |
| divPulse | output | 1 | One-clock pulse at the end of each period |
| cfgError | output | 1 | High while the applied setting is illegal |

## Verification
Two situations are hard to reach from the ports: a setting that changes in the middle of a period, and an illegal setting that arrives while a period is still running. Neither shows up in steady-state interval measurement. The stimulus first aligns to an observed pulse and then waits a few clocks before writing new values. The interval that follows must still match the old N, and the next one must match the new N. In the same way, an illegal value applied mid-period must let the running period finish with a pulse, followed by a long silent window, and a legal value applied while idle must bring the first pulse back after exactly N+1 samples.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int MODE_W = 2;

  typedef struct packed {
    logic              reload;    // start a new prescaler cycle
    logic              dualHigh;  // new cycle divides by P+1
    logic [MODE_W-1:0] mode;      // base modulus select for the new cycle
  } preCtl_t;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int BASE_LOG = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  preCtl_t ctl,
  output logic    preTerm
);
  localparam int MAX_LOG = BASE_LOG + (1 << MODE_W) - 1;
  localparam int PRE_W   = MAX_LOG + 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] baseMod;

  always_comb begin
    baseMod = PRE_W'(1) << (BASE_LOG + int'(ctl.mode));
  end

  // Down-counter: a cycle of P+1 clocks loads P, a cycle of P clocks loads P-1.
  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
    end else if (ctl.reload) begin
      preCnt <= ctl.dualHigh ? baseMod : baseMod - PRE_W'(1);
    end else if (preCnt != '0) begin
      preCnt <= preCnt - PRE_W'(1);
    end
  end

  assign preTerm = (preCnt == '0);

  // R3: the count never goes past the largest P+1 modulus.
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (rst)
    preCnt <= PRE_W'(1 << MAX_LOG));
endmodule

// File: rtl/psd_control.sv
module psd_control
  import psd_pkg::*;
#(
  parameter int SW_W     = 6,
  parameter int MAIN_W   = 13,
  parameter int MIN_MAIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [SW_W-1:0]   swallowVal,
  input  logic [MAIN_W-1:0] mainVal,
  input  logic              preTerm,
  output preCtl_t           ctl,
  output logic              divPulse,
  output logic              cfgError
);
  logic              active;
  logic [SW_W-1:0]   swCnt;
  logic [MAIN_W-1:0] mainCnt;
  logic [MODE_W-1:0] modeQ;
  logic              legal;
  logic              stepNow;
  logic              lastStep;
  logic              loadNow;

  always_comb begin
    legal    = (mainVal >= MAIN_W'(MIN_MAIN)) &&
               (mainVal >= MAIN_W'(swallowVal));
    stepNow  = active && preTerm;
    lastStep = stepNow && (mainCnt == MAIN_W'(1));
    loadNow  = legal && (!active || lastStep);
    ctl.reload   = loadNow || (stepNow && !lastStep);
    ctl.dualHigh = loadNow ? (swallowVal != '0) : (swCnt > SW_W'(1));
    ctl.mode     = loadNow ? modeSel : modeQ;
  end

  assign cfgError = !legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      swCnt    <= '0;
      mainCnt  <= '0;
      modeQ    <= '0;
      divPulse <= 1'b0;
    end else begin
      divPulse <= lastStep;
      if (loadNow) begin
        active  <= 1'b1;
        swCnt   <= swallowVal;
        mainCnt <= mainVal;
        modeQ   <= modeSel;
      end else if (lastStep) begin
        active <= 1'b0;
      end else if (stepNow) begin
        mainCnt <= mainCnt - MAIN_W'(1);
        if (swCnt != '0) swCnt <= swCnt - SW_W'(1);
      end
    end
  end

  // R2: a pulse never lasts more than one clock.
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  // R5: an idle divider produces no pulse on the next clock.
  a_r5_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !active |=> !divPulse);

  // R3: swallow cycles still to go never outnumber main cycles still to go.
  a_r3_swallow_le_main: assert property (@(posedge clk) disable iff (rst)
    active |-> (MAIN_W'(swCnt) <= mainCnt));

  // R6: the captured mode holds for the whole period.
  a_r6_mode_held: assert property (@(posedge clk) disable iff (rst)
    (active && !(preTerm && mainCnt == MAIN_W'(1))) |=> $stable(modeQ));

  // R1: a running period always has main cycles left.
  a_r1_main_nonzero: assert property (@(posedge clk) disable iff (rst)
    active |-> (mainCnt != '0));
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter int BASE_LOG = 3,
  parameter int SW_W     = 6,
  parameter int MAIN_W   = 13,
  parameter int MIN_MAIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        modeSel,
  input  logic [SW_W-1:0]   swallowVal,
  input  logic [MAIN_W-1:0] mainVal,
  output logic              divPulse,
  output logic              cfgError
);
  preCtl_t preCtl;
  logic    preTerm;

  psd_control #(
    .SW_W    (SW_W),
    .MAIN_W  (MAIN_W),
    .MIN_MAIN(MIN_MAIN)
  ) u_control (
    .clk       (clk),
    .rst       (rst),
    .modeSel   (modeSel),
    .swallowVal(swallowVal),
    .mainVal   (mainVal),
    .preTerm   (preTerm),
    .ctl       (preCtl),
    .divPulse  (divPulse),
    .cfgError  (cfgError)
  );

  psd_prescaler #(
    .BASE_LOG(BASE_LOG)
  ) u_prescaler (
    .clk    (clk),
    .rst    (rst),
    .ctl    (preCtl),
    .preTerm(preTerm)
  );
endmodule

// File: tb/pulse_swallow_divider_tb.sv
module pulse_swallow_divider_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  modeSel = '0;
  logic [5:0]  swallowVal = '0;
  logic [12:0] mainVal = 13'd3;
  logic        divPulse;
  logic        cfgError;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  pulse_swallow_divider u_dut (
    .clk       (clk),
    .rst       (rst),
    .modeSel   (modeSel),
    .swallowVal(swallowVal),
    .mainVal   (mainVal),
    .divPulse  (divPulse),
    .cfgError  (cfgError)
  );

  always #5 clk = ~clk;

  // Each entry is {mode, A, B}.
  localparam int NVEC = 8;
  localparam logic [20:0] VECS [NVEC] = '{
    {2'd0, 6'd5,  13'd10},
    {2'd1, 6'd0,  13'd7},   // A = 0
    {2'd2, 6'd3,  13'd3},   // A = B, minimum B
    {2'd3, 6'd1,  13'd4},
    {2'd0, 6'd63, 13'd63},  // A = B at the A maximum
    {2'd1, 6'd17, 13'd20},
    {2'd2, 6'd2,  13'd3},
    {2'd3, 6'd0,  13'd3}
  };

  function automatic int expN(logic [1:0] m, logic [5:0] a, logic [12:0] b);
    return (8 << m) * int'(b) + int'(a);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyVec(logic [20:0] v);
    modeSel    = v[20:19];
    swallowVal = v[18:13];
    mainVal    = v[12:0];
  endtask

  // Counts negedge samples up to and including the next one with divPulse high.
  task automatic waitPulse(output int cyc, input int limit);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!divPulse && cyc < limit);
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c;
    int c2;
    applyVec(VECS[0]);
    repeat (3) @(negedge clk);
    chk("R7 pulse low in reset", int'(divPulse), 0);
    rst = 1'b0;
    waitPulse(c, 5000);
    chk("R7 first pulse latency", c, expN(2'd0, 6'd5, 13'd10) + 1);

    for (int i = 0; i < NVEC; i++) begin
      applyVec(VECS[i]);
      waitPulse(c, 20000);  // boundary that captures the new values
      waitPulse(c, 20000);
      chk("R1/R3 period", c, expN(VECS[i][20:19], VECS[i][18:13], VECS[i][12:0]));
      chk("R4 legal setting flag", int'(cfgError), 0);
    end

    // R2: the pulse drops on the next clock.
    @(negedge clk);
    chk("R2 pulse width", int'(divPulse), 0);

    // R6: a change made mid-period takes effect only at the next boundary.
    waitPulse(c, 20000);
    repeat (5) @(negedge clk);
    applyVec(VECS[0]);
    waitPulse(c, 20000);
    chk("R6 running period kept", c + 5, expN(2'd3, 6'd0, 13'd3));
    waitPulse(c2, 20000);
    chk("R6 new period applied", c2, expN(2'd0, 6'd5, 13'd10));

    // R4: legality flag follows the inputs combinationally.
    repeat (3) @(negedge clk);
    mainVal = 13'd9; swallowVal = 6'd10; #1;
    chk("R4 B below A", int'(cfgError), 1);
    mainVal = 13'd3; swallowVal = 6'd3; #1;
    chk("R4 B equals A at minimum", int'(cfgError), 0);
    mainVal = 13'd3; swallowVal = 6'd4; #1;
    chk("R4 B one below A", int'(cfgError), 1);
    modeSel = 2'd0; mainVal = 13'd2; swallowVal = 6'd0; #1;
    chk("R4 B below minimum", int'(cfgError), 1);

    // R5: the period in progress finishes, then the output is silent.
    waitPulse(c, 20000);
    chk("R5 running period ends with pulse", int'(divPulse), 1);
    waitPulse(c, 1000);
    chk("R5 no pulse while illegal", c, 1000);
    chk("R5 output low while illegal", int'(divPulse), 0);

    // R5: recovery from idle with a legal setting.
    applyVec({2'd1, 6'd4, 13'd5});
    waitPulse(c, 20000);
    chk("R5 restart latency", c, expN(2'd1, 6'd4, 13'd5) + 1);
    waitPulse(c, 20000);
    chk("R1 period after restart", c, expN(2'd1, 6'd4, 13'd5));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule